// File: doc/BRIEF.md
# Timer DMA Burst Register Window

This block is the register front end of a timer peripheral. It adds a single data-window address through which a DMA controller can stream a run of consecutive timer registers without changing its own destination address. Each read or write that lands on the window is sent on to one register of a small internal array, which stands in for the timer's registers. The register is chosen by a programmed base offset plus a burst index that the hardware keeps.

A burst-control register holds the base offset and the burst length. After each window access the index moves forward by one. Once the access at index equal to the burst length is done, the index returns to zero, so the next DMA burst starts again at the base register. Writing the burst-control register also resets the index. A target that falls past the last implemented register reads as zero and takes no writes.

The bus is byte-addressed, one access per cycle, and carries 16 data bits. Write data is registered at the clock edge. Read data comes back combinationally in the same cycle as the access.

Top module: `tmr_burst_window`

## Requirements
- R1: After reset every array register, the base field, the length field and the burst index are zero, so reads of the control register, of the window and of any array register return 0x0000.
- R2: A write to the window (byte address 0x4C) stores its data in array register number base + index.
- R3: A read of the window returns the contents of array register number base + index.
- R4: Every window access, read or write, moves the burst index up by one when the index is below the burst length.
- R5: A window access made at index equal to the burst length sets the index back to 0. The index never exceeds the burst length.
- R6: A write to the control register (byte address 0x48) loads the base offset from data bits [4:0] and the burst length from bits [12:8], and clears the index to 0. A read of it returns those two fields in the same positions and zero in every other bit.
- R7: An access to any address other than the window, or a cycle with no access, leaves the burst index unchanged. The only exception is a control-register write (R6).
- R8: When base + index is 18 or more, a window write changes no register and a window read returns 0. The index still advances as in R4 and R5.
- R9: Array register k (0 to 17) can be read and written directly at byte address 4·k. Any other address, including an unaligned one, reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_en | input | 1 | An access is made this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 8 | Byte address of the access |
| acc_wdata | input | 16 | Write data |
| acc_rdata | output | 16 | Read data for the current access, 0 when no register answers |

## Verification
The assertions assume that every access is complete in one cycle, and that address, direction and write data are known and stay stable around the clock edge whenever the enable is high. The bench meets this by driving the inputs only at the falling edge and holding them until the next one. It only ever drives the enable as a clean level. Base and length values cover the whole 5-bit range, so sums that run past the last register and bursts that wrap at the largest length both appear, within the assumptions the properties make.

// File: rtl/tbw_pkg.sv
package tbw_pkg;

    typedef enum logic [2:0] {
        KIND_NONE,
        KIND_WIN,
        KIND_CTL,
        KIND_REG,
        KIND_BAD
    } acc_kind_e;

endpackage

// File: rtl/tbw_decode.sv
module tbw_decode
    import tbw_pkg::*;
#(
    parameter int          ADDR_W     = 8,
    parameter int          NUM_REGS   = 18,
    parameter logic [7:0]  WIN_OFFSET = 8'h4C,
    parameter logic [7:0]  CTL_OFFSET = 8'h48,
    localparam int         WORD_W     = ADDR_W - 2
) (
    input  logic              acc_en,
    input  logic [ADDR_W-1:0] acc_addr,
    output acc_kind_e         kind,
    output logic [WORD_W-1:0] word_idx
);

    logic aligned;
    logic in_array;

    always_comb begin
        word_idx = acc_addr[ADDR_W-1:2];
        aligned  = (acc_addr[1:0] == 2'b00);
        in_array = aligned && (word_idx < WORD_W'(NUM_REGS));
        if (!acc_en) begin
            kind = KIND_NONE;
        end else if (acc_addr == ADDR_W'(WIN_OFFSET)) begin
            kind = KIND_WIN;
        end else if (acc_addr == ADDR_W'(CTL_OFFSET)) begin
            kind = KIND_CTL;
        end else if (in_array) begin
            kind = KIND_REG;
        end else begin
            kind = KIND_BAD;
        end
    end

endmodule

// File: rtl/tbw_index.sv
module tbw_index #(
    parameter int FIELD_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               win_hit,
    input  logic               ctl_wr,
    input  logic [FIELD_W-1:0] new_base,
    input  logic [FIELD_W-1:0] new_len,
    output logic [FIELD_W-1:0] idx,
    output logic [FIELD_W-1:0] base,
    output logic [FIELD_W-1:0] len
);

    typedef struct packed {
        logic [FIELD_W-1:0] idx;
        logic [FIELD_W-1:0] base;
        logic [FIELD_W-1:0] len;
    } ix_state_t;

    ix_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctl_wr) begin
            st_d.base = new_base;
            st_d.len  = new_len;
            st_d.idx  = '0;
        end else if (win_hit) begin
            if (st_q.idx == st_q.len) begin
                st_d.idx = '0;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idx  = st_q.idx;
    assign base = st_q.base;
    assign len  = st_q.len;

endmodule

// File: rtl/tbw_regfile.sv
module tbw_regfile #(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 18,
    parameter int IDX_W    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] regs_d [NUM_REGS];
    logic [DATA_W-1:0] regs_q [NUM_REGS];

    always_comb begin
        for (int k = 0; k < NUM_REGS; k++) begin
            regs_d[k] = regs_q[k];
            if (wr_en && (wr_idx == IDX_W'(k))) begin
                regs_d[k] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_REGS; k++) begin
                regs_q[k] <= '0;
            end
        end else begin
            for (int k = 0; k < NUM_REGS; k++) begin
                regs_q[k] <= regs_d[k];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (rd_idx == IDX_W'(k)) begin
                rd_data = regs_q[k];
            end
        end
    end

endmodule

// File: rtl/tmr_burst_window.sv
module tmr_burst_window
    import tbw_pkg::*;
#(
    parameter int         DATA_W     = 16,
    parameter int         ADDR_W     = 8,
    parameter int         NUM_REGS   = 18,
    parameter int         FIELD_W    = 5,
    parameter int         LEN_LSB    = 8,
    parameter logic [7:0] WIN_OFFSET = 8'h4C,
    parameter logic [7:0] CTL_OFFSET = 8'h48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata
);

    localparam int WORD_W = ADDR_W - 2;
    localparam int SUM_W  = FIELD_W + 1;
    localparam int TGT_W  = (SUM_W > WORD_W) ? SUM_W : WORD_W;

    acc_kind_e          kind;
    logic [WORD_W-1:0]  word_idx;
    logic [FIELD_W-1:0] win_idx;
    logic [FIELD_W-1:0] win_base;
    logic [FIELD_W-1:0] win_len;
    logic [SUM_W-1:0]   win_sum;
    logic [TGT_W-1:0]   tgt_idx;
    logic               rf_wr;
    logic [DATA_W-1:0]  rf_rdata;
    logic [DATA_W-1:0]  ctl_view;
    logic               win_hit;
    logic               ctl_wr;

    tbw_decode #(
        .ADDR_W     (ADDR_W),
        .NUM_REGS   (NUM_REGS),
        .WIN_OFFSET (WIN_OFFSET),
        .CTL_OFFSET (CTL_OFFSET)
    ) u_dec (
        .acc_en   (acc_en),
        .acc_addr (acc_addr),
        .kind     (kind),
        .word_idx (word_idx)
    );

    assign win_hit = (kind == KIND_WIN);
    assign ctl_wr  = (kind == KIND_CTL) && acc_wr;

    tbw_index #(
        .FIELD_W (FIELD_W)
    ) u_idx (
        .clk      (clk),
        .rst_n    (rst_n),
        .win_hit  (win_hit),
        .ctl_wr   (ctl_wr),
        .new_base (acc_wdata[FIELD_W-1:0]),
        .new_len  (acc_wdata[LEN_LSB +: FIELD_W]),
        .idx      (win_idx),
        .base     (win_base),
        .len      (win_len)
    );

    always_comb begin
        win_sum = {1'b0, win_base} + {1'b0, win_idx};
        if (win_hit) begin
            tgt_idx = TGT_W'(win_sum);
        end else begin
            tgt_idx = TGT_W'(word_idx);
        end
        rf_wr = acc_wr && (win_hit || (kind == KIND_REG))
              && (tgt_idx < TGT_W'(NUM_REGS));
        ctl_view = '0;
        ctl_view[FIELD_W-1:0]       = win_base;
        ctl_view[LEN_LSB +: FIELD_W] = win_len;
    end

    tbw_regfile #(
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS),
        .IDX_W    (TGT_W)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (rf_wr),
        .wr_idx  (tgt_idx),
        .wr_data (acc_wdata),
        .rd_idx  (tgt_idx),
        .rd_data (rf_rdata)
    );

    always_comb begin
        case (kind)
            KIND_WIN, KIND_REG: acc_rdata = rf_rdata;
            KIND_CTL:           acc_rdata = ctl_view;
            default:            acc_rdata = '0;
        endcase
    end

endmodule

// File: rtl/tbw_checker.sv
module tbw_checker #(
    parameter int         DATA_W     = 16,
    parameter int         ADDR_W     = 8,
    parameter int         NUM_REGS   = 18,
    parameter int         FIELD_W    = 5,
    parameter int         LEN_LSB    = 8,
    parameter logic [7:0] WIN_OFFSET = 8'h4C,
    parameter logic [7:0] CTL_OFFSET = 8'h48
) (
    input logic               clk,
    input logic               rst_n,
    input logic               acc_en,
    input logic               acc_wr,
    input logic [ADDR_W-1:0]  acc_addr,
    input logic [DATA_W-1:0]  acc_wdata,
    input logic [DATA_W-1:0]  acc_rdata,
    input logic [FIELD_W-1:0] idx,
    input logic [FIELD_W-1:0] base,
    input logic [FIELD_W-1:0] len
);

    logic       on_win;
    logic       on_ctl_wr;
    logic       past_end;
    logic       no_reg;
    logic [7:0] sum_c;

    always_comb begin
        on_win    = acc_en && (acc_addr == ADDR_W'(WIN_OFFSET));
        on_ctl_wr = acc_en && acc_wr && (acc_addr == ADDR_W'(CTL_OFFSET));
        sum_c     = 8'(base) + 8'(idx);
        past_end  = (sum_c >= 8'(NUM_REGS));
        no_reg    = (acc_addr != ADDR_W'(WIN_OFFSET))
                 && (acc_addr != ADDR_W'(CTL_OFFSET))
                 && ((acc_addr[1:0] != 2'b00)
                     || (32'(acc_addr[ADDR_W-1:2]) >= NUM_REGS));
    end

    p_idx_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= len);

    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (on_win && !on_ctl_wr && (idx != len)) |=> (idx == $past(idx) + 1'b1));

    p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (on_win && (idx == len)) |=> (idx == '0));

    p_ctl_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        on_ctl_wr |=> (idx == '0));

    p_ctl_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        on_ctl_wr |=> ((base == $past(acc_wdata[FIELD_W-1:0]))
                       && (len == $past(acc_wdata[LEN_LSB +: FIELD_W]))));

    p_idx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!on_win && !on_ctl_wr) |=> $stable(idx));

    p_past_end_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (on_win && !acc_wr && past_end) |-> (acc_rdata == '0));

    p_no_reg_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_wr && no_reg) |-> (acc_rdata == '0));

endmodule

bind tmr_burst_window tbw_checker #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .NUM_REGS   (NUM_REGS),
    .FIELD_W    (FIELD_W),
    .LEN_LSB    (LEN_LSB),
    .WIN_OFFSET (WIN_OFFSET),
    .CTL_OFFSET (CTL_OFFSET)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_en    (acc_en),
    .acc_wr    (acc_wr),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata),
    .acc_rdata (acc_rdata),
    .idx       (win_idx),
    .base      (win_base),
    .len       (win_len)
);

// File: tb/sim_tmr_burst_window.sv
module sim_tmr_burst_window;

    localparam int NREG = 18;
    localparam logic [7:0] A_WIN = 8'h4C;
    localparam logic [7:0] A_CTL = 8'h48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0;
    logic        acc_wr = 1'b0;
    logic [7:0]  acc_addr = '0;
    logic [15:0] acc_wdata = '0;
    logic [15:0] acc_rdata;

    int n_checks = 0;
    int n_err = 0;

    logic [15:0] mregs [NREG];
    int mbase = 0;
    int mlen = 0;
    int midx = 0;

    always #2ns clk = ~clk;

    tmr_burst_window u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_en    (acc_en),
        .acc_wr    (acc_wr),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .acc_rdata (acc_rdata)
    );

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] model_rd(input logic [7:0] a);
        int t;
        if (a == A_WIN) begin
            t = mbase + midx;
            return (t < NREG) ? mregs[t] : 16'h0;
        end
        if (a == A_CTL) return 16'((mlen << 8) | mbase);
        if (a[1:0] == 2'b00 && int'(a >> 2) < NREG) return mregs[a >> 2];
        return 16'h0;
    endfunction

    task automatic model_upd(input bit wr, input logic [7:0] a, input logic [15:0] d);
        int t;
        if (a == A_WIN) begin
            t = mbase + midx;
            if (wr && t < NREG) mregs[t] = d;
            midx = (midx == mlen) ? 0 : midx + 1;
        end else if (a == A_CTL) begin
            if (wr) begin
                mbase = int'(d[4:0]);
                mlen  = int'(d[12:8]);
                midx  = 0;
            end
        end else if (wr && a[1:0] == 2'b00 && int'(a >> 2) < NREG) begin
            mregs[a >> 2] = d;
        end
    endtask

    task automatic access(input bit wr, input logic [7:0] a, input logic [15:0] d,
                          input string tag);
        @(negedge clk);
        acc_en = 1'b1;
        acc_wr = wr;
        acc_addr = a;
        acc_wdata = d;
        #1ns;
        if (!wr) check(acc_rdata, model_rd(a), tag);
        model_upd(wr, a, d);
    endtask

    task automatic idle();
        @(negedge clk);
        acc_en = 1'b0;
        acc_wr = 1'b0;
    endtask

    task automatic set_ctl(input int b, input int l, input string tag);
        access(1'b1, A_CTL, 16'((l << 8) | b), tag);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        n_checks++;
        $display("FAIL watchdog: got timeout expected finish");
        summary();
        $finish;
    end

    initial begin
        for (int k = 0; k < NREG; k++) mregs[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        access(1'b0, A_CTL, 16'h0, "R1 ctl");
        access(1'b0, 8'h00, 16'h0, "R1 reg0");
        access(1'b0, 8'h44, 16'h0, "R1 reg17");
        access(1'b0, A_WIN, 16'h0, "R1 window");

        // R9: direct register access
        for (int k = 0; k < NREG; k++) access(1'b1, 8'(k * 4), 16'(16'hA100 + k), "R9 wr");
        for (int k = 0; k < NREG; k++) access(1'b0, 8'(k * 4), 16'h0, "R9 rd");
        access(1'b1, 8'h50, 16'hDEAD, "R9 unmapped wr");
        access(1'b1, 8'h05, 16'hBEEF, "R9 unaligned wr");
        access(1'b0, 8'h50, 16'h0, "R9 unmapped rd");
        access(1'b0, 8'h05, 16'h0, "R9 unaligned rd");
        access(1'b0, 8'h04, 16'h0, "R9 reg1 intact");

        // R6: control register load and readback
        set_ctl(3, 4, "R6 set");
        access(1'b0, A_CTL, 16'h0, "R6 readback");
        access(1'b1, A_CTL, 16'hFFFF, "R6 extra bits");
        access(1'b0, A_CTL, 16'h0, "R6 masked");
        set_ctl(3, 4, "R6 set again");

        // R2, R4: window writes walk base..base+len
        for (int k = 0; k < 5; k++) access(1'b1, A_WIN, 16'(16'h5000 + k), "R2 win wr");
        for (int k = 2; k < 9; k++) access(1'b0, 8'(k * 4), 16'h0, "R2 landed");

        // R3, R5: reads wrap back to base
        for (int k = 0; k < 7; k++) access(1'b0, A_WIN, 16'h0, "R3 R5 win rd");

        // R7: other accesses and idle cycles do not move the index
        access(1'b0, A_WIN, 16'h0, "R7 a");
        access(1'b0, 8'h08, 16'h0, "R7 other rd");
        access(1'b1, 8'h40, 16'h1234, "R7 other wr");
        idle();
        idle();
        access(1'b0, A_WIN, 16'h0, "R7 b");

        // R6: control write mid-burst restarts at base
        access(1'b0, A_WIN, 16'h0, "R6 pre");
        set_ctl(3, 4, "R6 restart");
        access(1'b0, A_WIN, 16'h0, "R6 from base");

        // R8: targets beyond the array
        set_ctl(16, 3, "R8 set");
        for (int k = 0; k < 4; k++) access(1'b1, A_WIN, 16'(16'hC0C0 + k), "R8 win wr");
        for (int k = 0; k < 4; k++) access(1'b0, A_WIN, 16'h0, "R8 win rd");
        set_ctl(31, 31, "R8 far");
        for (int k = 0; k < 3; k++) access(1'b1, A_WIN, 16'hEEEE, "R8 far wr");
        for (int k = 0; k < NREG; k++) access(1'b0, 8'(k * 4), 16'h0, "R8 array intact");

        // R4: long burst with maximum length wraps after 32 accesses
        set_ctl(0, 31, "R4 set");
        for (int k = 0; k < 34; k++) access(1'b0, A_WIN, 16'h0, "R4 R5 long");

        // R4: random mix against the model
        for (int k = 0; k < 600; k++) begin
            int sel;
            logic [15:0] d;
            sel = int'($urandom_range(0, 9));
            d = 16'($urandom);
            if (sel < 5) access(d[0], A_WIN, d, "R4 rnd win");
            else if (sel == 5) access(1'b1, A_CTL, d, "R6 rnd ctl");
            else if (sel == 6) access(1'b0, A_CTL, d, "R6 rnd ctl rd");
            else if (sel == 7) access(d[1], 8'(4 * $urandom_range(0, NREG - 1)), d, "R9 rnd reg");
            else if (sel == 8) access(d[2], 8'($urandom_range(0, 255)), d, "R9 rnd any");
            else idle();
        end

        idle();
        summary();
        $finish;
    end

endmodule